// File: doc/BRIEF.md
# RAM, Port and Interval-Timer Peripheral

This block hangs off the address bus of an 8-bit processor system. It combines two 8-bit general-purpose ports, each with a per-bit direction register, a 64-byte scratch memory and an 8-bit interval timer. The timer's clock divider and its interrupt enable are chosen by the address used for the access, not by data bits. Software writes a start count to one of eight timer addresses. It then polls a passed-zero status bit or waits for the active-low interrupt line.

The block decodes two 64-byte windows, each at its own base address parameter. One window holds the port and timer registers and the other holds the scratch memory. Every access is a single clock cycle, qualified by `acc_vld`, with `acc_wr` selecting a write. Read data comes from a register and is valid, together with `rd_vld`, in the cycle after the address is presented.

Top module: `ramio_timer_periph`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both direction registers and both output latches, clears the timer's interrupt enable and passed-zero flag, and stops the timer until it is first loaded. After reset, pa_oe, pb_oe, pa_out and pb_out are 0, irq_n is 1 and the status byte reads 0x00.
- R2: In the port/timer window the register is chosen by the address bits [3:0], and this pattern repeats every 16 bytes across the window. Offset 0 is the port A output latch, 1 is the port A direction, 2 is the port B latch and 3 is the port B direction. Offsets 8 to B reach the same four registers. pX_out shows the latch and pX_oe shows the direction register (1 means output).
- R3: Reading a port data offset returns, bit by bit, the latch where the direction bit is 1 and the external input pX_in where it is 0.
- R4: A write to offset 4, 5, 6 or 7 loads the written byte as the timer count, restarts the divider and selects a divide ratio of 1, 8, 64 or 1024. Offsets C to F do the same with the same ratio order. Address bit 3 sets the interrupt enable (1 at C to F, 0 at 4 to 7). The count drops by one after every full divider period.
- R5: When a timer tick occurs with the count at 0x00, the count wraps to 0xFF and the passed-zero flag is set. For a load value N and ratio D, this happens at the (N+1)*D-th clock edge after the loading edge. A read at offset 5, 7, D or F returns a status byte whose bit 7 is the flag and whose other bits are 0. The read has no side effect.
- R6: While the passed-zero flag is set, the count drops by one on every clock, whatever ratio was chosen.
- R7: A read at offset 4, 6, C or E returns the count. It clears the passed-zero flag and sets the interrupt enable to address bit 3, so 6 disables and E enables. Loading a new count also clears the flag.
- R8: irq_n is 0 exactly while the passed-zero flag is set and the interrupt enable is 1.
- R9: A write into the memory window stores the byte at address bits [5:0], and a later read at that address returns it.
- R10: An access outside both windows changes no register, port or memory byte. It leaves rd_vld at 0, and rdata is 0x00 whenever rd_vld is 0.
- R11: A read inside either window sets rd_vld to 1 in the next cycle, with rdata holding the addressed value as it was at the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Bus access this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_vld | output | 1 | rdata holds a window read |
| pa_in | input | 8 | Port A external input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B external input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| irq_n | output | 1 | Timer interrupt, active low |

## Verification
The port reads use mixed direction masks against two different pin patterns, so a swapped latch/pin selection or an inverted mask gives a different byte. Mirror addresses and one address high in the window show whether the decode ignores bits [5:4]. Probes just below the port window and just above the memory window expose a loose base compare. The timer is loaded with each of the four ratios, and the status or count is sampled one edge before and one edge after the predicted wrap or tick. An off-by-one in the divider, the wrap or the ratio order therefore shows as a wrong value. A zero load is followed by a full count cycle, once with the interrupt disabled and once enabled through a count read, which separates the enable-by-address rule from the flag itself.

// File: rtl/ramio_pkg.sv
// Shared types for the RAM/port/timer peripheral.
// Assumes the divider selector codes follow address bits [1:0] of a timer access.
package ramio_pkg;

    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_8    = 2'd1,
        DIV_64   = 2'd2,
        DIV_1024 = 2'd3
    } div_sel_e;

    // Decoded view of address bits [3:0] inside the port/timer window.
    typedef struct packed {
        logic       irq_sel;  // bit 3: interrupt enable choice
        logic       timer;    // bit 2: timer rather than port
        logic [1:0] low;      // bits 1:0: port/direction or divider
    } io_off_t;

    // Last value of the divider counter for a given ratio.
    function automatic logic [PRE_W-1:0] div_last(input div_sel_e s);
        case (s)
            DIV_1:   return PRE_W'(0);
            DIV_8:   return PRE_W'(7);
            DIV_64:  return PRE_W'(63);
            default: return PRE_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/ramio_port.sv
// One general-purpose port: an output latch, a per-bit direction register and the read-back mix.
// Assumes a direction bit of 1 means the bit drives its latch value.
module ramio_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lat,
    input  logic              wr_dir,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin,
    output logic [DATA_W-1:0] lat,
    output logic [DATA_W-1:0] dir,
    output logic [DATA_W-1:0] rd_val
);

    // Latch and direction registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
            dir <= '0;
        end else begin
            if (wr_lat) lat <= wdata;
            if (wr_dir) dir <= wdata;
        end
    end

    // Read-back: latch on output bits, pin on input bits.
    assign rd_val = (lat & dir) | (pin & ~dir);

endmodule

// File: rtl/ramio_timer.sv
// Interval timer: loadable down-counter behind a selectable divider, with a passed-zero flag.
// Assumes load and count-read strobes are single-cycle; a load overrides a simultaneous read.
module ramio_timer
    import ramio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  div_sel_e          load_div,
    input  logic              load_irq,
    input  logic              rd_cnt,
    input  logic              rd_irq,
    output logic [DATA_W-1:0] cnt,
    output logic              flag,
    output logic              irq_n
);

    logic [PRE_W-1:0] pre;
    div_sel_e         div;
    logic             irq_en;
    logic             armed;
    logic             pre_wrap;
    logic             tick;

    // Divider end and count tick; after passing zero every clock ticks.
    assign pre_wrap = (pre == div_last(div));
    assign tick     = armed && (flag || pre_wrap);

    // Count, divider, flag and enable update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pre    <= '0;
            div    <= DIV_1;
            flag   <= 1'b0;
            irq_en <= 1'b0;
            armed  <= 1'b0;
        end else if (load) begin
            cnt    <= load_val;
            pre    <= '0;
            div    <= load_div;
            flag   <= 1'b0;
            irq_en <= load_irq;
            armed  <= 1'b1;
        end else begin
            if (armed) pre <= pre_wrap ? '0 : pre + 1'b1;
            if (tick) begin
                cnt <= cnt - 1'b1;
                if (cnt == '0) flag <= 1'b1;
            end
            if (rd_cnt) begin
                flag   <= 1'b0;
                irq_en <= rd_irq;
            end
        end
    end

    // Interrupt line, low while an enabled flag is pending.
    assign irq_n = !(flag && irq_en);

endmodule

// File: rtl/ramio_scratch.sv
// Scratch memory of 2**DEPTH_W bytes; synchronous write, combinational read (registered by the top).
// Assumes no reset of contents.
module ramio_scratch #(
    parameter int DATA_W  = 8,
    parameter int DEPTH_W = 6
) (
    input  logic               clk,
    input  logic               we,
    input  logic [DEPTH_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_val
);

    localparam int DEPTH = 1 << DEPTH_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Byte write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Addressed byte, sampled by the top's read register.
    assign rd_val = mem[addr];

endmodule

// File: rtl/ramio_timer_periph.sv
// Top: decodes the port/timer and memory windows, routes accesses and registers read data.
// Assumes both base addresses are aligned to the window size and the windows do not overlap.
module ramio_timer_periph
    import ramio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_W  = 6,
    parameter logic [ADDR_W-1:0] IO_BASE  = 'h0200,
    parameter logic [ADDR_W-1:0] RAM_BASE = 'h0280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    output logic              irq_n
);

    localparam int N_PORTS = 2;

    logic              io_hit, ram_hit, io_wr, io_rd, rd_hit;
    io_off_t           off;
    logic [DATA_W-1:0] pin_v  [N_PORTS];
    logic [DATA_W-1:0] lat_v  [N_PORTS];
    logic [DATA_W-1:0] dir_v  [N_PORTS];
    logic [DATA_W-1:0] prd_v  [N_PORTS];
    logic [DATA_W-1:0] ram_rd, t_cnt, rd_next;
    logic              t_flag;

    // Window decode on the address bits above the window size.
    assign io_hit  = acc_vld && (addr[ADDR_W-1:WIN_W] == IO_BASE[ADDR_W-1:WIN_W]);
    assign ram_hit = acc_vld && (addr[ADDR_W-1:WIN_W] == RAM_BASE[ADDR_W-1:WIN_W]);
    assign io_wr   = io_hit && acc_wr;
    assign io_rd   = io_hit && !acc_wr;
    assign rd_hit  = (io_hit || ram_hit) && !acc_wr;
    assign off     = io_off_t'(addr[3:0]);

    assign pin_v[0] = pa_in;
    assign pin_v[1] = pb_in;
    assign pa_out   = lat_v[0];
    assign pa_oe    = dir_v[0];
    assign pb_out   = lat_v[1];
    assign pb_oe    = dir_v[1];

    // One port instance per port, selected by address bit 1.
    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        ramio_port #(.DATA_W(DATA_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lat (io_wr && !off.timer && (off.low[1] == 1'(g)) && !off.low[0]),
            .wr_dir (io_wr && !off.timer && (off.low[1] == 1'(g)) &&  off.low[0]),
            .wdata  (wdata),
            .pin    (pin_v[g]),
            .lat    (lat_v[g]),
            .dir    (dir_v[g]),
            .rd_val (prd_v[g])
        );
    end

    ramio_timer #(.DATA_W(DATA_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (io_wr && off.timer),
        .load_val (wdata),
        .load_div (div_sel_e'(off.low)),
        .load_irq (off.irq_sel),
        .rd_cnt   (io_rd && off.timer && !off.low[0]),
        .rd_irq   (off.irq_sel),
        .cnt      (t_cnt),
        .flag     (t_flag),
        .irq_n    (irq_n)
    );

    ramio_scratch #(.DATA_W(DATA_W), .DEPTH_W(WIN_W)) u_ram (
        .clk    (clk),
        .we     (ram_hit && acc_wr),
        .addr   (addr[WIN_W-1:0]),
        .wdata  (wdata),
        .rd_val (ram_rd)
    );

    // Read source selection for the addressed register.
    always_comb begin
        rd_next = '0;
        if (ram_hit) begin
            rd_next = ram_rd;
        end else if (io_hit) begin
            if (!off.timer)
                rd_next = off.low[0] ? dir_v[off.low[1]] : prd_v[off.low[1]];
            else if (!off.low[0])
                rd_next = t_cnt;
            else
                rd_next = {t_flag, {(DATA_W-1){1'b0}}};
        end
    end

    // Registered read data and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_hit;
            rdata  <= rd_hit ? rd_next : '0;
        end
    end

endmodule

// File: rtl/ramio_timer_periph_chk.sv
// Checker for ramio_timer_periph, attached by bind; relates bus accesses to port-visible results.
module ramio_timer_periph_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_W  = 6,
    parameter logic [ADDR_W-1:0] IO_BASE  = 'h0200,
    parameter logic [ADDR_W-1:0] RAM_BASE = 'h0280
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_vld,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_vld,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic              irq_n
);

    logic io_win, ram_win;
    assign io_win  = addr[ADDR_W-1:WIN_W] == IO_BASE[ADDR_W-1:WIN_W];
    assign ram_win = addr[ADDR_W-1:WIN_W] == RAM_BASE[ADDR_W-1:WIN_W];

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && io_win && (addr[3:0] == 4'h1 || addr[3:0] == 4'h9))
        |=> pa_oe == $past(wdata));

    p_quiet_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && io_win && addr[3:2] == 2'b01) |=> irq_n);

    p_read_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_wr && (io_win || ram_win)) |=> rd_vld);

    p_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_vld && !acc_wr && (io_win || ram_win)) |=> !rd_vld);

    p_idle_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> rdata == '0);

    p_ports_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_vld && acc_wr && io_win)
        |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pa_out) && $stable(pb_out)));

endmodule

bind ramio_timer_periph ramio_timer_periph_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
    .IO_BASE(IO_BASE), .RAM_BASE(RAM_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .irq_n(irq_n)
);

// File: tb/ramio_timer_periph_tb_top.sv
// Self-checking bench: vector table for ports and memory, directed tests for reset and timer.
module ramio_timer_periph_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  pin;
        logic        chk;
        logic        exp_vld;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h0201, 8'hF0, 8'h00, 1'b0, 1'b0, 8'h00, 8'd2},  // R2 A dir
        '{1'b1, 16'h0200, 8'hAA, 8'h00, 1'b0, 1'b0, 8'h00, 8'd2},  // R2 A latch
        '{1'b0, 16'h0200, 8'h00, 8'h0F, 1'b1, 1'b1, 8'hAF, 8'd3},  // R3 mix
        '{1'b0, 16'h0201, 8'h00, 8'h00, 1'b1, 1'b1, 8'hF0, 8'd2},  // R2
        '{1'b0, 16'h0209, 8'h00, 8'h00, 1'b1, 1'b1, 8'hF0, 8'd2},  // R2 mirror
        '{1'b1, 16'h020B, 8'h3C, 8'h00, 1'b0, 1'b0, 8'h00, 8'd2},  // R2 B dir via mirror
        '{1'b0, 16'h0203, 8'h00, 8'h00, 1'b1, 1'b1, 8'h3C, 8'd2},  // R2
        '{1'b1, 16'h0202, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 8'd2},  // R2 B latch
        '{1'b0, 16'h020A, 8'h00, 8'h00, 1'b1, 1'b1, 8'h14, 8'd3},  // R3
        '{1'b0, 16'h0208, 8'h00, 8'h33, 1'b1, 1'b1, 8'hA3, 8'd3},  // R3 mirror
        '{1'b1, 16'h0280, 8'h12, 8'h00, 1'b0, 1'b0, 8'h00, 8'd9},  // R9
        '{1'b1, 16'h02BF, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'd9},  // R9 top byte
        '{1'b0, 16'h0280, 8'h00, 8'h00, 1'b1, 1'b1, 8'h12, 8'd9},  // R9
        '{1'b0, 16'h02BF, 8'h00, 8'h00, 1'b1, 1'b1, 8'h9A, 8'd9},  // R9
        '{1'b0, 16'h0300, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'd10}, // R10 outside
        '{1'b1, 16'h0300, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 8'd10}, // R10 stray write
        '{1'b1, 16'h01C1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'd10}, // R10 stray write
        '{1'b0, 16'h0201, 8'h00, 8'h00, 1'b1, 1'b1, 8'hF0, 8'd10}, // R10 dir kept
        '{1'b0, 16'h0280, 8'h00, 8'h00, 1'b1, 1'b1, 8'h12, 8'd10}, // R10 memory kept
        '{1'b0, 16'h0220, 8'h00, 8'h00, 1'b1, 1'b1, 8'hA0, 8'd2},  // R2 16-byte repeat
        '{1'b0, 16'h02C0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'd10}  // R10 past memory
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_vld;
    logic [7:0]  pa_in = '0;
    logic [7:0]  pa_out, pa_oe;
    logic [7:0]  pb_in = '0;
    logic [7:0]  pb_out, pb_oe;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ramio_timer_periph dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge: one access on the next posedge, returns at the following negedge.
    task automatic bus_op(input logic wr, input logic [15:0] a, input logic [7:0] d);
        acc_vld = 1'b1;
        acc_wr  = wr;
        addr    = a;
        wdata   = d;
        @(negedge clk);
        acc_vld = 1'b0;
        acc_wr  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 pa_oe", 32'(pa_oe), 32'h00);
        check("R1 pb_oe", 32'(pb_oe), 32'h00);
        check("R1 pa_out", 32'(pa_out), 32'h00);
        check("R1 irq_n", 32'(irq_n), 32'h1);
        check("R1 rd_vld idle", 32'(rd_vld), 32'h0);
        bus_op(1'b0, 16'h0207, 8'h00);
        check("R1 status", 32'(rdata), 32'h00);

        // Table walk: ports, mirrors, memory, outside addresses
        for (int i = 0; i < NVEC; i++) begin
            pa_in = VEC[i].pin;
            pb_in = VEC[i].pin;
            bus_op(VEC[i].wr, VEC[i].addr, VEC[i].wd);
            if (VEC[i].chk) begin
                check($sformatf("R%0d vec %0d rd_vld", VEC[i].req, i), 32'(rd_vld), 32'(VEC[i].exp_vld));
                check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), 32'(rdata), 32'(VEC[i].exp));
            end
        end
        // R11 valid asserted after an in-window read
        bus_op(1'b0, 16'h0203, 8'h00);
        check("R11 rd_vld", 32'(rd_vld), 32'h1);
        check("R2 pa_out", 32'(pa_out), 32'hAA);
        check("R2 pa_oe", 32'(pa_oe), 32'hF0);
        check("R2 pb_out", 32'(pb_out), 32'h55);
        check("R2 pb_oe", 32'(pb_oe), 32'h3C);

        // Divide by 1, interrupt enabled, load 3: flag at 4th edge
        bus_op(1'b1, 16'h020C, 8'h03);
        check("R4 irq_n after load", 32'(irq_n), 32'h1);
        idle(3);
        check("R5 irq_n before wrap", 32'(irq_n), 32'h1);
        idle(1);
        check("R8 irq_n at wrap", 32'(irq_n), 32'h0);
        idle(2);
        bus_op(1'b0, 16'h020E, 8'h00);
        check("R6 count after wrap", 32'(rdata), 32'hFD);
        check("R7 irq_n after count read", 32'(irq_n), 32'h1);

        // Divide by 8, interrupt disabled, load 2: flag at 24th edge
        bus_op(1'b1, 16'h0205, 8'h02);
        idle(22);
        bus_op(1'b0, 16'h0207, 8'h00);
        check("R5 status before wrap", 32'(rdata), 32'h00);
        idle(1);
        bus_op(1'b0, 16'h0207, 8'h00);
        check("R5 status after wrap", 32'(rdata), 32'h80);
        check("R4 irq disabled", 32'(irq_n), 32'h1);
        bus_op(1'b0, 16'h0206, 8'h00);
        bus_op(1'b0, 16'h0207, 8'h00);
        check("R7 status cleared by count read", 32'(rdata), 32'h00);

        // Divide by 1024, load 0x50: first tick at edge 1024
        bus_op(1'b1, 16'h0207, 8'h50);
        bus_op(1'b0, 16'h0206, 8'h00);
        check("R4 count held", 32'(rdata), 32'h50);
        idle(1022);
        bus_op(1'b0, 16'h0206, 8'h00);
        check("R4 count before first tick", 32'(rdata), 32'h50);
        bus_op(1'b0, 16'h0206, 8'h00);
        check("R4 count after first tick", 32'(rdata), 32'h4F);

        // Divide by 64, interrupt enabled, load 1: flag at 128th edge
        bus_op(1'b1, 16'h020E, 8'h01);
        idle(127);
        check("R5 irq_n before wrap d64", 32'(irq_n), 32'h1);
        idle(1);
        check("R8 irq_n at wrap d64", 32'(irq_n), 32'h0);
        bus_op(1'b1, 16'h0204, 8'h10);
        check("R7 reload clears flag", 32'(irq_n), 32'h1);

        // Enable chosen by count-read address
        bus_op(1'b1, 16'h020C, 8'h00);
        idle(1);
        check("R8 irq_n zero load", 32'(irq_n), 32'h0);
        bus_op(1'b0, 16'h0206, 8'h00);
        idle(300);
        check("R7 disabled by offset 6", 32'(irq_n), 32'h1);
        bus_op(1'b0, 16'h0207, 8'h00);
        check("R5 flag set again", 32'(rdata), 32'h80);
        bus_op(1'b0, 16'h020E, 8'h00);
        check("R7 irq_n after enabling read", 32'(irq_n), 32'h1);
        idle(300);
        check("R7 enabled by offset E", 32'(irq_n), 32'h0);

        // R1 reset while flag pending and ports programmed
        do_reset();
        check("R1 irq_n after reset", 32'(irq_n), 32'h1);
        check("R1 pa_oe after reset", 32'(pa_oe), 32'h00);
        check("R1 pb_out after reset", 32'(pb_out), 32'h00);
        bus_op(1'b0, 16'h020F, 8'h00);
        check("R1 status after reset", 32'(rdata), 32'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule